// File: doc/BRIEF.md
# Keypad Autosleep and Autowake Controller

This block decides when a key-scan engine runs and when it sleeps. While operating, it counts 1 ms ticks of key inactivity. When an autosleep timeout is programmed and the idle count runs past it, the block enters sleep. In sleep it turns off the matrix drive enable and the scan enable. Stored key events are never touched by this block, so sleeping loses nothing already captured.

Two things end sleep. One is a host write that sets the wake bit of the configuration register. The other is any keypress, but only while autowake is allowed. After either wake, the matrix drive comes back at once, but the scan enable stays low for a fixed settle interval counted in ticks. The key that caused the wake is not consumed or cleared. The downstream debouncer starts on it when the scan enable rises, so a held key is recorded after settle plus debounce.

The configuration register reads back with bit 7 as the live sleep flag and bit 1 as the autowake enable. A separate 3-bit timeout field selects the autosleep time, and a value of 0 turns autosleep off.

Top module: `kp_sleep_ctrl`

## Requirements
- R1: After reset the block is operating: `drive_en`=1 and `scan_en`=1. `cfg_rdata` reads 8'h02, meaning bit 7 (sleep) is 0, bit 1 (autowake) is 1, and the timeout code is 0.
- R2: With timeout code 0, the block never enters sleep, however many idle ticks arrive.
- R3: With timeout code n from 1 to 7, the timeout is T = BASE_TICKS << (n-1) ticks. Sleep begins in the cycle after the (T+1)-th consecutive tick that has `key_any` low. From then on, `cfg_rdata[7]`=1, `drive_en`=0 and `scan_en`=0.
- R4: While operating, two things restart the idle count from zero: a cycle with `key_any` high, or a write to the timeout field. A key that stays held prevents sleep.
- R5: In sleep, a `cfg_wr` with `cfg_wdata[7]`=1 leaves sleep in the next cycle: `cfg_rdata[7]` goes to 0 and `drive_en` goes to 1. This works whatever the autowake setting.
- R6: In sleep with autowake set, `key_any` high leaves sleep in the next cycle, with `drive_en`=1 and `scan_en`=0.
- R7: In sleep with autowake cleared, `key_any` has no effect. A `cfg_wr` with bit 7 at 0 also has no effect. The block stays asleep with `drive_en`=0.
- R8: After a wake, `scan_en` stays 0 while `drive_en` is 1. `scan_en` rises in the cycle after the SETTLE_TICKS-th tick that follows the wake.
- R9: A write with bit 7 set while the block is operating has no effect on the mode. `cfg_rdata[7]` stays 0 and `scan_en` stays 1.
- R10: `cfg_rdata[1]` returns the bit 1 of the last `cfg_wr`. All bits other than 7 and 1 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse every 1 ms |
| key_any | input | 1 | High while any matrix key is seen pressed |
| cfg_wr | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 8 | Write data: bit 7 wake, bit 1 autowake enable |
| tmo_wr | input | 1 | Timeout field write strobe |
| tmo_wdata | input | 3 | Timeout code, 0 disables autosleep |
| cfg_rdata | output | 8 | Bit 7 sleep status, bit 1 autowake enable |
| drive_en | output | 1 | Matrix current-source enable |
| scan_en | output | 1 | Permits debounce and event capture |

## Verification
The bench builds the block with BASE_TICKS=2 and SETTLE_TICKS=2. With these values the timeouts for codes 1 and 3 are 2 and 8 ticks, so each sleep entry, and the tick right before it, is reached within a few dozen cycles. The short settle interval makes it possible to check the exact tick at which scanning resumes, for both a host wake and a key wake. The same values are used to show that autowake is ignored when disabled and that a held key holds off sleep.

// File: rtl/kp_sleep_ctrl.sv
module kp_sleep_ctrl #(
  parameter int BASE_TICKS   = 8,
  parameter int SETTLE_TICKS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       key_any,
  input  logic       cfg_wr,
  input  logic [7:0] cfg_wdata,
  input  logic       tmo_wr,
  input  logic [2:0] tmo_wdata,
  output logic [7:0] cfg_rdata,
  output logic       drive_en,
  output logic       scan_en
);
  localparam int MAX_T = BASE_TICKS << 6;
  localparam int IW = $clog2(MAX_T + 1);
  localparam int SW = $clog2(SETTLE_TICKS + 1);

  typedef enum logic [1:0] {S_RUN, S_SLEEP, S_SETTLE} mode_t;

  mode_t        st;
  logic [IW-1:0] idle_cnt, limit;
  logic [SW-1:0] set_cnt;
  logic [2:0]    code;
  logic          aw_en;

  wire host_wake = cfg_wr && cfg_wdata[7];
  wire key_wake  = key_any && aw_en;
  wire unused_cfg_bits = ^{cfg_wdata[6:2], cfg_wdata[0]};

  assign limit = (code == 3'd0) ? '0 : (IW'(BASE_TICKS) << (code - 3'd1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_RUN;
      idle_cnt <= '0;
      set_cnt  <= '0;
      code     <= 3'd0;
      aw_en    <= 1'b1;
    end else begin
      if (cfg_wr) aw_en <= cfg_wdata[1];
      if (tmo_wr) code <= tmo_wdata;
      case (st)
        S_RUN: begin
          if (key_any || tmo_wr) idle_cnt <= '0;
          else if (tick && code != 3'd0) begin
            if (idle_cnt == limit) begin
              st       <= S_SLEEP;
              idle_cnt <= '0;
            end else idle_cnt <= idle_cnt + 1'b1;
          end
        end
        S_SLEEP: begin
          if (host_wake || key_wake) begin
            st      <= S_SETTLE;
            set_cnt <= '0;
          end
        end
        default: begin
          idle_cnt <= '0;
          if (tick) begin
            if (set_cnt == SW'(SETTLE_TICKS - 1)) st <= S_RUN;
            else set_cnt <= set_cnt + 1'b1;
          end
        end
      endcase
    end
  end

  assign drive_en  = (st != S_SLEEP);
  assign scan_en   = (st == S_RUN);
  assign cfg_rdata = {st == S_SLEEP, 5'd0, aw_en, 1'b0};

  a_r5_host_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SLEEP && host_wake) |=> (cfg_rdata[7] == 1'b0 && drive_en));

  a_r6_key_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SLEEP && key_any && aw_en) |=> (drive_en && !scan_en));

  a_r7_no_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SLEEP && !aw_en && !host_wake) |=> cfg_rdata[7]);

  a_r8_scan_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scan_en) |-> $past(tick));

  a_r8_scan_needs_drive: assert property (@(posedge clk) disable iff (!rst_n)
    !drive_en |-> !scan_en);

  a_r2_never_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    (code == 3'd0 && !tmo_wr && st == S_RUN) |=> !cfg_rdata[7]);

  a_r4_key_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && key_any) |=> !cfg_rdata[7]);
endmodule

// File: tb/kp_sleep_ctrl_tb.sv
module kp_sleep_ctrl_tb;
  logic       clk = 0, rst_n = 0, tick = 0, key_any = 0;
  logic       cfg_wr = 0, tmo_wr = 0;
  logic [7:0] cfg_wdata = 0;
  logic [2:0] tmo_wdata = 0;
  logic [7:0] cfg_rdata;
  logic       drive_en, scan_en;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  typedef struct { string tag; logic [7:0] rd; logic drv; logic scn; } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  kp_sleep_ctrl #(.BASE_TICKS(2), .SETTLE_TICKS(2)) u_dut (
    .clk, .rst_n, .tick, .key_any, .cfg_wr, .cfg_wdata, .tmo_wr, .tmo_wdata,
    .cfg_rdata, .drive_en, .scan_en);

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_run++;
      if (cfg_rdata !== e.rd || drive_en !== e.drv || scan_en !== e.scn) begin
        n_fail++;
        $display("FAIL %s: got rd=%h drv=%b scan=%b, expected rd=%h drv=%b scan=%b",
                 e.tag, cfg_rdata, drive_en, scan_en, e.rd, e.drv, e.scn);
      end
    end
  end

  task automatic step(); @(posedge clk); #1; endtask
  task automatic expect_(string tag, logic [7:0] rd, logic drv, logic scn);
    exp_t e; e.tag = tag; e.rd = rd; e.drv = drv; e.scn = scn;
    q.push_back(e);
    @(negedge clk); #1;
  endtask
  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin tick = 1; step(); tick = 0; step(); end
  endtask
  task automatic cfg(logic [7:0] d);
    cfg_wr = 1; cfg_wdata = d; step(); cfg_wr = 0;
  endtask
  task automatic tmo(logic [2:0] c);
    tmo_wr = 1; tmo_wdata = c; step(); tmo_wr = 0;
  endtask

  initial begin
    #1600000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hung, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    step(); step(); rst_n = 1; step();
    expect_("R1 reset", 8'h02, 1, 1);
    ticks(10);
    expect_("R2 code 0 never sleeps", 8'h02, 1, 1);
    tmo(3'd1);
    ticks(2);
    expect_("R3 awake at T ticks", 8'h02, 1, 1);
    ticks(1);
    expect_("R3 asleep after T+1", 8'h82, 0, 0);
    cfg(8'h00);
    expect_("R7 bit7=0 write keeps sleep", 8'h80, 0, 0);
    key_any = 1; step(); ticks(3);
    expect_("R7 key ignored w/o autowake", 8'h80, 0, 0);
    key_any = 0; step();
    cfg(8'h80);
    expect_("R5 host wake", 8'h00, 1, 0);
    ticks(1);
    expect_("R8 settle after 1 tick", 8'h00, 1, 0);
    ticks(1);
    expect_("R8 scan after 2 ticks", 8'h00, 1, 1);
    ticks(2);
    key_any = 1; step(); key_any = 0;
    ticks(2);
    expect_("R4 key restarts count", 8'h00, 1, 1);
    ticks(1);
    expect_("R3 asleep again", 8'h80, 0, 0);
    cfg(8'h02);
    expect_("R10 autowake bit set, still asleep", 8'h82, 0, 0);
    key_any = 1; step();
    expect_("R6 key wake", 8'h02, 1, 0);
    ticks(1);
    expect_("R8 key wake settle", 8'h02, 1, 0);
    ticks(1);
    expect_("R8 key wake scan", 8'h02, 1, 1);
    ticks(6);
    expect_("R4 held key blocks sleep", 8'h02, 1, 1);
    key_any = 0; step();
    cfg(8'h82);
    expect_("R9 wake write while running", 8'h02, 1, 1);
    cfg(8'hFD);
    expect_("R10 other bits read 0", 8'h00, 1, 1);
    cfg(8'h02);
    tmo(3'd3);
    ticks(8);
    expect_("R3 code 3 awake at 8", 8'h02, 1, 1);
    ticks(1);
    expect_("R3 code 3 asleep at 9", 8'h82, 0, 0);
    cfg(8'h82);
    ticks(2);
    tmo(3'd0);
    ticks(40);
    expect_("R2 disabled after write", 8'h02, 1, 1);
    step(); step();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule